// File: doc/BRIEF.md
# Oversampled Serial Receiver with Ninth-Bit Address Filter

This block takes an asynchronous serial line and a one-cycle-wide oversampling strobe that pulses sixteen times per bit period. It synchronises the line, looks for a falling edge, confirms the start bit at its centre, and then takes one sample in the middle of every later bit. The frame can carry eight data bits, with an optional parity bit, or nine data bits. The received word, together with its parity-error and framing-error flags, goes into a small first-in first-out store. The consumer drains that store through a registered read port.

In nine-bit mode an address filter can be switched on. It keeps only words whose ninth bit is one, which lets a node on a shared multi-drop line ignore data meant for others. A word that arrives while the store is full is thrown away and a sticky overrun flag is raised. A data interrupt shows that words are waiting. A separate error interrupt shows that a stored word carries an error or that an overrun has happened. An active-low request-to-send output goes high when the store is close to full, so the far transmitter pauses.

Top module: `uart_rx_addr`

## Requirements
- R1: After reset `irq_data`, `irq_err`, `ovr_flag`, `rts_n` and `rd_valid` are all 0.
- R2: A low level that has ended before the eighth strobe after the falling edge is not taken as a start bit, and no word is stored.
- R3: In eight-bit mode the data bits are received least significant bit first, each sampled once at the centre of its bit period. `rd_data[8]` reads 0.
- R4: `cfg_par` selects the parity check in eight-bit mode only. 2'b00 and 2'b11 mean no parity bit. 2'b01 means even parity: the data bits plus the parity bit hold an even number of ones. 2'b10 means odd parity. A mismatch is returned as `rd_perr`=1 with that word.
- R5: With `cfg_nine`=1 a frame carries nine data bits and no parity bit, and the ninth bit received appears on `rd_data[8]`.
- R6: With `cfg_nine`=1 and `cfg_addr`=1, a word whose ninth bit is 0 is dropped and a word whose ninth bit is 1 is stored.
- R7: A stop bit sampled low stores the word with `rd_ferr`=1.
- R8: The store holds four words and returns them in arrival order. A one-cycle `rd_en` while `irq_data`=1 gives `rd_valid`=1 in the next cycle, with the word and its flags on `rd_data`, `rd_perr` and `rd_ferr`.
- R9: A frame that completes while four words are held is discarded. `ovr_flag` is then set and stays set until `ovr_clr` is pulsed.
- R10: `irq_data` is 1 exactly when the store is non-empty. `irq_err` is 1 while any stored word has an error flag or `ovr_flag` is set.
- R11: `rts_n` is 1 while three or more words are held and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Oversampling strobe, 16 per bit |
| rxd | input | 1 | Serial line, idles high |
| cfg_nine | input | 1 | 1 = nine data bits |
| cfg_par | input | 2 | Parity select for eight-bit mode |
| cfg_addr | input | 1 | Address filter enable (nine-bit mode) |
| rd_en | input | 1 | Pop one word |
| ovr_clr | input | 1 | Clear the overrun flag |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 9 | Received word |
| rd_perr | output | 1 | Parity error of the word read |
| rd_ferr | output | 1 | Framing error of the word read |
| ovr_flag | output | 1 | Sticky overrun flag |
| irq_data | output | 1 | Words are waiting |
| irq_err | output | 1 | Error pending |
| rts_n | output | 1 | Active-low request to send |

## Verification
If the bit counter or the sample phase is wrong, the bits shift. The first frame read back is then wrong, and parity and stop checks flag errors on frames sent clean. If the occupancy count drifts, `rts_n` and `irq_data` disagree with the number of frames sent a few cycles after a stop bit, and overrun comes one frame early or late. If the per-entry error marks are not cleared on pop, `irq_err` stays high after the faulty word has been drained.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int WORD_W = 9;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic              perr;
    logic              ferr;
    logic [WORD_W-1:0] data;
  } rx_word_t;

  localparam int ENTRY_W = $bits(rx_word_t);
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     line,
  input  logic     cfg_nine,
  input  logic [1:0] cfg_par,
  output logic     done,
  output rx_word_t word
);
  localparam int CNT_W   = $clog2(OVS);
  localparam int HALF    = OVS / 2 - 1;
  localparam int FULL    = OVS - 1;
  localparam int IDX_W   = $clog2(WORD_W);

  rx_state_e         st;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] shreg;
  logic              prev;
  logic              par_acc;
  logic              perr_q;

  logic              par_on;
  logic [IDX_W-1:0]  last_idx;

  assign par_on   = !cfg_nine && (cfg_par == 2'b01 || cfg_par == 2'b10);
  assign last_idx = cfg_nine ? IDX_W'(WORD_W - 1) : IDX_W'(WORD_W - 2);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      idx     <= '0;
      shreg   <= '0;
      prev    <= 1'b1;
      par_acc <= 1'b0;
      perr_q  <= 1'b0;
      done    <= 1'b0;
      word    <= '0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        prev <= line;
        unique case (st)
          ST_IDLE: begin
            if (prev && !line) begin
              st  <= ST_START;
              cnt <= '0;
            end
          end
          ST_START: begin
            if (cnt == CNT_W'(HALF)) begin
              cnt <= '0;
              if (!line) begin
                st      <= ST_DATA;
                idx     <= '0;
                shreg   <= '0;
                par_acc <= 1'b0;
                perr_q  <= 1'b0;
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (cnt == CNT_W'(FULL)) begin
              cnt        <= '0;
              shreg[idx] <= line;
              par_acc    <= par_acc ^ line;
              if (idx == last_idx) st <= par_on ? ST_PAR : ST_STOP;
              else                 idx <= idx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_PAR: begin
            if (cnt == CNT_W'(FULL)) begin
              cnt <= '0;
              st  <= ST_STOP;
              if (cfg_par == 2'b01) perr_q <= par_acc ^ line;
              else                  perr_q <= ~(par_acc ^ line);
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_STOP: begin
            if (cnt == CNT_W'(FULL)) begin
              cnt       <= '0;
              st        <= ST_IDLE;
              done      <= 1'b1;
              word.data <= shreg;
              word.perr <= perr_q;
              word.ferr <= !line;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3
  eight_bit_top_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !cfg_nine && $stable(cfg_nine)) |-> !word.data[WORD_W-1]);
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int W     = 11,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [W-1:0]               wr_data,
  input  logic                       wr_mark,
  input  logic                       rd_en,
  output logic                       rd_valid,
  output logic [W-1:0]               rd_data,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty,
  output logic                       any_mark
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [DEPTH-1:0] mark;
  logic [PTR_W-1:0] wptr, rptr;
  logic             do_rd;

  assign full     = (count == CNT_W'(DEPTH));
  assign empty    = (count == '0);
  assign do_rd    = rd_en && !empty;
  assign any_mark = |mark;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
    if (do_rd) rd_data <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      mark     <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= do_rd;
      if (wr_en) wptr <= wptr + 1'b1;
      if (do_rd) rptr <= rptr + 1'b1;
      for (int i = 0; i < DEPTH; i++) begin
        if (do_rd && rptr == PTR_W'(i))      mark[i] <= 1'b0;
        else if (wr_en && wptr == PTR_W'(i)) mark[i] <= wr_mark;
      end
      unique case ({wr_en, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full);

  // R8
  rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en));

  // R8
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));
endmodule

// File: rtl/uart_rx_addr.sv
module uart_rx_addr
  import uart_rx_pkg::*;
#(
  parameter int OVS       = 16,
  parameter int DEPTH     = 4,
  parameter int RTS_LEVEL = DEPTH - 1,
  parameter int SYNC      = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick16,
  input  logic       rxd,
  input  logic       cfg_nine,
  input  logic [1:0] cfg_par,
  input  logic       cfg_addr,
  input  logic       rd_en,
  input  logic       ovr_clr,
  output logic       rd_valid,
  output logic [8:0] rd_data,
  output logic       rd_perr,
  output logic       rd_ferr,
  output logic       ovr_flag,
  output logic       irq_data,
  output logic       irq_err,
  output logic       rts_n
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic                 line;
  logic                 fr_done;
  rx_word_t             fr_word;
  logic                 keep;
  logic                 push;
  logic                 fifo_full, fifo_empty, any_mark;
  logic [CNT_W-1:0]     count;
  logic [ENTRY_W-1:0]   rd_raw;
  rx_word_t             rd_word;

  uart_rx_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst(rst), .din(rxd), .dout(line)
  );

  uart_rx_framer #(.OVS(OVS)) u_framer (
    .clk(clk), .rst(rst), .tick(tick16), .line(line),
    .cfg_nine(cfg_nine), .cfg_par(cfg_par),
    .done(fr_done), .word(fr_word)
  );

  assign keep = !(cfg_addr && cfg_nine && !fr_word.data[WORD_W-1]);
  assign push = fr_done && keep && !fifo_full;

  uart_rx_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .wr_en(push), .wr_data(fr_word), .wr_mark(fr_word.perr | fr_word.ferr),
    .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_raw),
    .count(count), .full(fifo_full), .empty(fifo_empty), .any_mark(any_mark)
  );

  assign rd_word = rx_word_t'(rd_raw);
  assign rd_data = rd_word.data;
  assign rd_perr = rd_word.perr;
  assign rd_ferr = rd_word.ferr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_flag <= 1'b0;
      irq_data <= 1'b0;
      irq_err  <= 1'b0;
      rts_n    <= 1'b0;
    end else begin
      if (fr_done && keep && fifo_full) ovr_flag <= 1'b1;
      else if (ovr_clr)                 ovr_flag <= 1'b0;
      irq_data <= !fifo_empty;
      irq_err  <= ovr_flag | any_mark;
      rts_n    <= (count >= CNT_W'(RTS_LEVEL));
    end
  end

  // R9
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovr_flag && !ovr_clr) |=> ovr_flag);

  // R6
  addr_filter_chk: assert property (@(posedge clk) disable iff (rst)
    (push && cfg_addr && cfg_nine) |-> fr_word.data[WORD_W-1]);

  // R10
  irq_err_ovr_chk: assert property (@(posedge clk) disable iff (rst)
    ovr_flag |=> irq_err);
endmodule

// File: tb/tb_uart_rx_addr.sv
module tb_uart_rx_addr;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int BIT_CLKS   = 16 * TICK_DIV;
  localparam int WATCHDOG   = 150000;

  typedef struct {
    logic [8:0] data;
    logic       perr;
    logic       ferr;
    string      req;
  } exp_t;

  logic       clk = 0;
  logic       rst = 1;
  logic       tick16 = 0;
  logic       rxd = 1;
  logic       cfg_nine = 0;
  logic [1:0] cfg_par = 0;
  logic       cfg_addr = 0;
  logic       rd_en = 0;
  logic       ovr_clr = 0;
  logic       rd_valid, rd_perr, rd_ferr, ovr_flag, irq_data, irq_err, rts_n;
  logic [8:0] rd_data;

  int   n_chk = 0;
  int   n_bad = 0;
  int   cyc = 0;
  int   tdiv = 0;
  bit   done_flag = 0;
  exp_t expq[$];

  uart_rx_addr dut (
    .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd),
    .cfg_nine(cfg_nine), .cfg_par(cfg_par), .cfg_addr(cfg_addr),
    .rd_en(rd_en), .ovr_clr(ovr_clr),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr),
    .ovr_flag(ovr_flag), .irq_data(irq_data), .irq_err(irq_err), .rts_n(rts_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tdiv   <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    tick16 <= (tdiv == TICK_DIV - 1);
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG && !done_flag) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, actual %0d cycles, expected < %0d", cyc, WATCHDOG);
      summary();
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: compare each read word with the scoreboard head
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (expq.size() == 0) begin
        n_chk++;
        n_bad++;
        $display("FAIL R8: unexpected word actual %0h expected none", rd_data);
      end else begin
        exp_t e;
        e = expq.pop_front();
        chk({e.req, " data"}, {23'd0, rd_data}, {23'd0, e.data});
        chk({e.req, " perr"}, {31'd0, rd_perr}, {31'd0, e.perr});
        chk({e.req, " ferr"}, {31'd0, rd_ferr}, {31'd0, e.ferr});
      end
    end
  end

  task automatic bit_out(logic b);
    rxd = b;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  // driver: send one frame and, if it should be kept, queue the expected word
  task automatic send(logic [8:0] d, logic bad_par, logic bad_stop,
                      logic store, string req);
    int   nb;
    logic p;
    logic par_on;
    exp_t e;
    nb     = cfg_nine ? 9 : 8;
    par_on = !cfg_nine && (cfg_par == 2'b01 || cfg_par == 2'b10);
    p      = 1'b0;
    bit_out(1'b0);
    for (int i = 0; i < nb; i++) begin
      bit_out(d[i]);
      p ^= d[i];
    end
    if (par_on) begin
      if (cfg_par == 2'b10) p = ~p;
      bit_out(p ^ bad_par);
    end
    bit_out(!bad_stop);
    bit_out(1'b1);
    if (store) begin
      e.data = cfg_nine ? d : {1'b0, d[7:0]};
      e.perr = par_on && bad_par;
      e.ferr = bad_stop;
      e.req  = req;
      expq.push_back(e);
    end
  endtask

  task automatic drain();
    while (irq_data) begin
      rd_en = 1;
      @(negedge clk);
      rd_en = 0;
      repeat (3) @(negedge clk);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq_data", irq_data, 0);
    chk("R1 irq_err", irq_err, 0);
    chk("R1 ovr_flag", ovr_flag, 0);
    chk("R1 rts_n", rts_n, 0);
    chk("R1 rd_valid", rd_valid, 0);
    repeat (BIT_CLKS) @(negedge clk);

    // R2 short low glitch is not a start bit
    rxd = 0;
    repeat (3 * TICK_DIV) @(negedge clk);
    rxd = 1;
    repeat (2 * BIT_CLKS) @(negedge clk);
    chk("R2 glitch ignored", irq_data, 0);

    // R3 eight-bit frames, no parity
    send(9'h05A, 0, 0, 1, "R3");
    send(9'h181, 0, 0, 1, "R3");
    chk("R10 irq_data with words", irq_data, 1);
    chk("R10 irq_err clean", irq_err, 0);
    drain();
    chk("R10 irq_data empty", irq_data, 0);

    // R4 parity modes
    cfg_par = 2'b01;
    send(9'h0A5, 0, 0, 1, "R4 even ok");
    send(9'h037, 1, 0, 1, "R4 even bad");
    chk("R10 irq_err on parity error", irq_err, 1);
    cfg_par = 2'b10;
    send(9'h0A5, 0, 0, 1, "R4 odd ok");
    send(9'h010, 1, 0, 1, "R4 odd bad");
    drain();
    chk("R10 irq_err cleared after drain", irq_err, 0);
    cfg_par = 2'b11;
    send(9'h0C3, 0, 0, 1, "R4 none");
    drain();

    // R5 nine-bit frames, parity setting ignored
    cfg_par  = 2'b01;
    cfg_nine = 1;
    send(9'h1C3, 0, 0, 1, "R5");
    send(9'h042, 0, 0, 1, "R5");
    drain();

    // R6 address filter
    cfg_addr = 1;
    send(9'h142, 0, 0, 1, "R6 keep");
    send(9'h033, 0, 0, 0, "R6 drop");
    send(9'h1FF, 0, 0, 1, "R6 keep");
    drain();
    cfg_addr = 0;
    cfg_nine = 0;
    cfg_par  = 2'b00;

    // R7 framing error
    send(9'h066, 0, 1, 1, "R7");
    chk("R10 irq_err on framing error", irq_err, 1);
    drain();

    // R8 / R9 / R11 fill, overrun and order
    send(9'h011, 0, 0, 1, "R8 order");
    send(9'h022, 0, 0, 1, "R8 order");
    chk("R11 rts_n at two", rts_n, 0);
    send(9'h033, 0, 0, 1, "R8 order");
    chk("R11 rts_n at three", rts_n, 1);
    send(9'h044, 0, 0, 1, "R8 order");
    chk("R9 no overrun at four", ovr_flag, 0);
    send(9'h055, 0, 0, 0, "R9 discarded");
    chk("R9 ovr_flag set", ovr_flag, 1);
    chk("R10 irq_err on overrun", irq_err, 1);
    drain();
    chk("R9 ovr_flag sticky", ovr_flag, 1);
    chk("R11 rts_n after drain", rts_n, 0);
    ovr_clr = 1;
    @(negedge clk);
    ovr_clr = 0;
    repeat (2) @(negedge clk);
    chk("R9 ovr_flag cleared", ovr_flag, 0);
    chk("R10 irq_err cleared", irq_err, 0);
    chk("R8 all words returned", expq.size(), 0);

    done_flag = 1;
    summary();
  end
endmodule